// File: doc/BRIEF.md
# Serial Wire Debug Target Request Responder

This block is the target-side front end of a two-wire serial debug port. It runs on the host-supplied debug clock and watches the bidirectional data line for request headers. A well-formed header is followed by one turnaround cycle and a three-bit acknowledge from the target. The transfer then either shifts out a 32-bit word with parity or takes in a 32-bit word and checks its parity. Requests addressed to the debug port reach four local registers: a fixed identification word, a control/status word that holds a sticky write-error flag, an access-port bank selector and a buffer holding the most recent access-port read. Requests addressed to the access port are forwarded as single-cycle strobes on a simple register port.

Errors are handled in two ways. A malformed header is a protocol error: the target releases the line and stays silent until the host sends a line reset. A write whose data parity is wrong sets the sticky flag. While that flag is set, every access-port request receives a FAULT acknowledge until the host clears the flag. A busy input turns access-port requests into WAIT acknowledges. The port drives and samples the line on the rising clock edge, and its line-drive outputs are registered.

Top module: `swd_target_port`

## Requirements
- R1: A request starts with a 1 sampled in idle. It is followed by access-port select, read flag, address bit 2, address bit 3, parity, stop and park, in that order. After the park bit comes one cycle with the line released, then three acknowledge cycles driven LSB first. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100. The target never drives the line during a header or a turnaround.
- R2: A header is malformed if its parity bit differs from the XOR of the four preceding field bits, if its stop bit is 1 or if its park bit is 0. After a malformed header the target drives nothing and answers no request, including later well-formed ones.
- R3: LR_CYCLES consecutive high samples (default 50) abort any transfer, clear the protocol lockout and leave the port idle. One cycle fewer does not.
- R4: A read with an OK acknowledge drives 32 data bits LSB first, then one parity bit equal to the XOR of the data. After that comes one turnaround cycle with the line released. Address 0 of the debug port reads as the IDCODE parameter.
- R5: A write with an OK acknowledge has one turnaround cycle, then takes 32 data bits LSB first and one parity bit. When the parity matches, the addressed register is updated.
- R6: A write whose parity bit differs from the XOR of its data sets the sticky flag (control/status bit 0). It changes no register and produces no access-port write strobe.
- R7: While the sticky flag is set, access-port requests get FAULT and debug-port requests still get OK. Writing a 1 to bit 0 of debug-port address 0 clears the flag.
- R8: While ap_busy is high, access-port requests get WAIT. When the sticky flag is also set, FAULT takes priority.
- R9: An access-port read raises ap_rd_en for the one turnaround cycle after the header, and ap_rdata is taken at the last acknowledge cycle. An access-port write raises ap_wr_en for the single cycle after its parity bit. ap_addr is {bank, address bit 3, address bit 2}.
- R10: Debug-port address 1 reads back the control field in bits [8 +: CTRL_W] and the sticky flag in bit 0, and a write sets the field. Address 2 holds the bank in its low BANK_W bits. Address 3 returns the last access-port read data, and writes to address 3 are ignored.
- R11: After a WAIT or FAULT acknowledge the target releases the line for one cycle and returns to idle. There is no data phase and no access-port strobe.
- R12: After reset the line is released and both access-port strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock from the host |
| rst | input | 1 | Synchronous active-high reset |
| swdio_in | input | 1 | Sampled level of the data line |
| swdio_out | output | 1 | Level the target drives on the data line |
| swdio_oe | output | 1 | Target drives the data line when high |
| ap_busy | input | 1 | Forces WAIT on access-port requests |
| ap_addr | output | BANK_W+2 | Access-port register address |
| ap_wr_en | output | 1 | Access-port write strobe |
| ap_wdata | output | DATA_W | Access-port write data |
| ap_rd_en | output | 1 | Access-port read strobe |
| ap_rdata | input | DATA_W | Access-port read data |

## Verification
The acknowledge decision for an access-port request can meet two causes at once: a pending sticky error and a raised busy input. The bench provokes this by first sending a write with a deliberately wrong parity bit and then holding ap_busy high during the next access-port read. The three acknowledge cycles on the line must show FAULT (line bits 0,0,1) and not WAIT, with no read strobe and no data phase. A second overlap occurs when a write strobe falls in the first header cycle of a request sent back-to-back. The per-cycle model expects the strobe, its address and its data in exactly that cycle.

// File: rtl/swd_tgt_pkg.sv
package swd_tgt_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_HDR, PH_TRN1, PH_ACK, PH_RD, PH_TRN2, PH_TRNW, PH_WR, PH_LOCK
  } phase_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  // header bits after the start bit, first received in bit 0
  localparam int HDR_TAIL = 7;

  typedef struct packed {
    logic       ap;
    logic       rnw;
    logic [1:0] addr;
  } req_t;

  // [0] port sel, [1] read, [3:2] address, [4] parity, [5] stop, [6] park
  function automatic logic hdr_valid(input logic [HDR_TAIL-1:0] h);
    return ((^h[3:0]) == h[4]) && !h[5] && h[6];
  endfunction

endpackage

// File: rtl/swd_linereset_det.sv
module swd_linereset_det #(
  parameter int LR_CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lr_now
);
  localparam int RUN_W = $clog2(LR_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LR_CYCLES - 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)               run_q <= '0;
    else if (!din)         run_q <= '0;
    else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
  end

  // high in every cycle whose sample completes a run of LR_CYCLES ones
  assign lr_now = din && (run_q == RUN_TOP);
endmodule

// File: rtl/swd_dp_regs.sv
module swd_dp_regs #(
  parameter int          DATA_W = 32,
  parameter int          CTRL_W = 8,
  parameter int          BANK_W = 4,
  parameter logic [31:0] IDCODE = 32'h0C5D_1E37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              perr_set,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] rdata,
  output logic              sticky,
  output logic [BANK_W-1:0] bank
);
  localparam int CTRL_LSB = 8;

  logic              sticky_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] rdbuf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= 1'b0;
      ctrl_q   <= '0;
      bank_q   <= '0;
      rdbuf_q  <= '0;
    end else begin
      if (perr_set) begin
        sticky_q <= 1'b1;
      end else if (we) begin
        case (addr)
          2'd0: if (wdata[0]) sticky_q <= 1'b0;
          2'd1: ctrl_q <= wdata[CTRL_LSB +: CTRL_W];
          2'd2: bank_q <= wdata[BANK_W-1:0];
          default: ;
        endcase
      end
      if (cap) rdbuf_q <= cap_data;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata = DATA_W'(IDCODE);
      2'd1: begin
        rdata[0]                  = sticky_q;
        rdata[CTRL_LSB +: CTRL_W] = ctrl_q;
      end
      2'd2: rdata[BANK_W-1:0] = bank_q;
      default: rdata = rdbuf_q;
    endcase
  end

  assign sticky = sticky_q;
  assign bank   = bank_q;
endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_tgt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic              lr_now,
  input  logic              sticky,
  input  logic              ap_busy,
  input  logic [DATA_W-1:0] dp_rdata,
  input  logic [DATA_W-1:0] ap_rdata,
  output logic              swdio_out,
  output logic              swdio_oe,
  output logic              locked,
  output logic [1:0]        reg_addr,
  output logic              dp_we,
  output logic              wr_perr,
  output logic              ap_rd_cap,
  output logic [DATA_W-1:0] wr_word,
  output logic              ap_wr_en,
  output logic              ap_rd_en,
  output logic [DATA_W-1:0] ap_wdata
);
  localparam int SH_W  = DATA_W + 1;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_TAIL - 1);
  localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(2);

  phase_e              ph_q, ph_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [HDR_TAIL-1:0] hdr_q, hdr_n;
  req_t                req_q, req_n;
  logic [2:0]          ack_q, ack_n;
  logic [SH_W-1:0]     sh_q, sh_n;
  logic [SH_W-1:0]     word_in;
  logic [DATA_W-1:0]   wdat_q, wdat_n;
  logic                oe_n, out_n, apw_n, apr_n;
  logic [DATA_W-1:0]   rd_word;

  always_comb begin
    ph_n      = ph_q;
    cnt_n     = cnt_q;
    hdr_n     = hdr_q;
    req_n     = req_q;
    ack_n     = ack_q;
    sh_n      = sh_q;
    wdat_n    = wdat_q;
    apw_n     = 1'b0;
    apr_n     = 1'b0;
    dp_we     = 1'b0;
    wr_perr   = 1'b0;
    ap_rd_cap = 1'b0;
    word_in   = {din, sh_q[SH_W-1:1]};
    wr_word   = word_in[DATA_W-1:0];
    rd_word   = req_q.ap ? ap_rdata : dp_rdata;

    case (ph_q)
      PH_IDLE: begin
        if (din) begin
          ph_n  = PH_HDR;
          cnt_n = '0;
        end
      end
      PH_HDR: begin
        hdr_n = {din, hdr_q[HDR_TAIL-1:1]};
        if (cnt_q == HDR_LAST) begin
          if (!hdr_valid(hdr_n)) begin
            ph_n = PH_LOCK;
          end else begin
            req_n.ap   = hdr_n[0];
            req_n.rnw  = hdr_n[1];
            req_n.addr = hdr_n[3:2];
            if (hdr_n[0] && sticky)       ack_n = ACK_FAULT;
            else if (hdr_n[0] && ap_busy) ack_n = ACK_WAIT;
            else                          ack_n = ACK_OK;
            sh_n       = '0;
            sh_n[2:0]  = ack_n;
            apr_n      = hdr_n[0] && hdr_n[1] && (ack_n == ACK_OK);
            ph_n       = PH_TRN1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_TRN1: begin
        ph_n  = PH_ACK;
        cnt_n = '0;
      end
      PH_ACK: begin
        if (cnt_q == ACK_LAST) begin
          cnt_n = '0;
          if (ack_q != ACK_OK) begin
            ph_n = PH_TRN2;
          end else if (req_q.rnw) begin
            sh_n      = {^rd_word, rd_word};
            ap_rd_cap = req_q.ap;
            ph_n      = PH_RD;
          end else begin
            ph_n = PH_TRNW;
          end
        end else begin
          sh_n  = sh_q >> 1;
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_RD: begin
        if (cnt_q == CNT_LAST) begin
          ph_n = PH_TRN2;
        end else begin
          sh_n  = sh_q >> 1;
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_TRN2: ph_n = PH_IDLE;
      PH_TRNW: begin
        ph_n  = PH_WR;
        cnt_n = '0;
      end
      PH_WR: begin
        sh_n = word_in;
        if (cnt_q == CNT_LAST) begin
          ph_n = PH_IDLE;
          if ((^word_in[DATA_W-1:0]) != word_in[DATA_W]) begin
            wr_perr = 1'b1;
          end else if (req_q.ap) begin
            apw_n  = 1'b1;
            wdat_n = word_in[DATA_W-1:0];
          end else begin
            dp_we = 1'b1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: ph_n = PH_LOCK;
    endcase

    if (lr_now) begin
      ph_n      = PH_IDLE;
      apw_n     = 1'b0;
      apr_n     = 1'b0;
      dp_we     = 1'b0;
      wr_perr   = 1'b0;
      ap_rd_cap = 1'b0;
    end

    oe_n  = (ph_n == PH_ACK) || (ph_n == PH_RD);
    out_n = oe_n && sh_n[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      req_q     <= '0;
      ack_q     <= ACK_OK;
      sh_q      <= '0;
      wdat_q    <= '0;
      swdio_oe  <= 1'b0;
      swdio_out <= 1'b0;
      ap_wr_en  <= 1'b0;
      ap_rd_en  <= 1'b0;
    end else begin
      ph_q      <= ph_n;
      cnt_q     <= cnt_n;
      hdr_q     <= hdr_n;
      req_q     <= req_n;
      ack_q     <= ack_n;
      sh_q      <= sh_n;
      wdat_q    <= wdat_n;
      swdio_oe  <= oe_n;
      swdio_out <= out_n;
      ap_wr_en  <= apw_n;
      ap_rd_en  <= apr_n;
    end
  end

  assign locked   = (ph_q == PH_LOCK);
  assign reg_addr = req_q.addr;
  assign ap_wdata = wdat_q;
endmodule

// File: rtl/swd_target_port.sv
module swd_target_port #(
  parameter int          DATA_W    = 32,
  parameter int          CTRL_W    = 8,
  parameter int          BANK_W    = 4,
  parameter int          LR_CYCLES = 50,
  parameter logic [31:0] IDCODE    = 32'h0C5D_1E37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swdio_in,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              ap_busy,
  output logic [BANK_W+1:0] ap_addr,
  output logic              ap_wr_en,
  output logic [DATA_W-1:0] ap_wdata,
  output logic              ap_rd_en,
  input  logic [DATA_W-1:0] ap_rdata
);
  logic              lr_now;
  logic              seq_locked;
  logic [1:0]        reg_addr;
  logic              dp_we, wr_perr, ap_rd_cap, sticky;
  logic [DATA_W-1:0] wr_word, dp_rdata;
  logic [BANK_W-1:0] bank;

  swd_linereset_det #(.LR_CYCLES(LR_CYCLES)) u_lr (
    .clk(clk), .rst(rst), .din(swdio_in), .lr_now(lr_now)
  );

  swd_dp_regs #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .BANK_W(BANK_W), .IDCODE(IDCODE)
  ) u_regs (
    .clk(clk), .rst(rst), .we(dp_we), .addr(reg_addr), .wdata(wr_word),
    .perr_set(wr_perr), .cap(ap_rd_cap), .cap_data(ap_rdata),
    .rdata(dp_rdata), .sticky(sticky), .bank(bank)
  );

  swd_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .din(swdio_in), .lr_now(lr_now), .sticky(sticky),
    .ap_busy(ap_busy), .dp_rdata(dp_rdata), .ap_rdata(ap_rdata),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .locked(seq_locked),
    .reg_addr(reg_addr), .dp_we(dp_we), .wr_perr(wr_perr),
    .ap_rd_cap(ap_rd_cap), .wr_word(wr_word), .ap_wr_en(ap_wr_en),
    .ap_rd_en(ap_rd_en), .ap_wdata(ap_wdata)
  );

  assign ap_addr = {bank, reg_addr};
endmodule

// File: rtl/swd_target_port_chk.sv
module swd_target_port_chk #(
  parameter int DATA_W = 32
) (
  input logic clk,
  input logic rst,
  input logic swdio_oe,
  input logic ap_wr_en,
  input logic ap_rd_en,
  input logic locked,
  input logic lr_now
);
  logic [7:0] drv_run;

  always_ff @(posedge clk) begin
    if (rst)           drv_run <= '0;
    else if (swdio_oe) drv_run <= drv_run + 1'b1;
    else               drv_run <= '0;
  end

  // R2: a locked port leaves the line alone
  a_r2_locked_silent: assert property (@(posedge clk) disable iff (rst)
    locked |-> !swdio_oe);

  // R3: a completed line reset ends the lockout with the line released
  a_r3_lr_unlocks: assert property (@(posedge clk) disable iff (rst)
    lr_now |=> (!locked && !swdio_oe));

  // R4: longest target drive is three ack bits plus data and parity
  a_r4_drive_bound: assert property (@(posedge clk) disable iff (rst)
    swdio_oe |-> (drv_run < 8'(DATA_W + 4)));

  // R9: strobes are single-cycle and never together
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(ap_wr_en && ap_rd_en));

  a_r9_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    ap_wr_en |=> !ap_wr_en);

  // R9: read strobe sits in the turnaround before the ack
  a_r9_rd_in_turnaround: assert property (@(posedge clk) disable iff (rst)
    ap_rd_en |-> !swdio_oe);
endmodule

bind swd_target_port swd_target_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .swdio_oe(swdio_oe), .ap_wr_en(ap_wr_en),
  .ap_rd_en(ap_rd_en), .locked(seq_locked), .lr_now(lr_now)
);

// File: tb/tb_swd_target_port.sv
`timescale 1ns/100ps
module tb_swd_target_port;
  localparam int          DATA_W = 32;
  localparam int          BANK_W = 4;
  localparam int          LR     = 50;
  localparam logic [31:0] IDC    = 32'h0C5D_1E37;
  localparam int          NAP    = 1 << (BANK_W + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swdio_in = 1'b0;
  logic ap_busy = 1'b0;
  logic swdio_out, swdio_oe, ap_wr_en, ap_rd_en;
  logic [BANK_W+1:0] ap_addr;
  logic [DATA_W-1:0] ap_wdata, ap_rdata;

  always #2.5 clk = ~clk;

  swd_target_port #(.LR_CYCLES(LR), .IDCODE(IDC)) dut (
    .clk(clk), .rst(rst), .swdio_in(swdio_in), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .ap_busy(ap_busy), .ap_addr(ap_addr),
    .ap_wr_en(ap_wr_en), .ap_wdata(ap_wdata), .ap_rd_en(ap_rd_en),
    .ap_rdata(ap_rdata)
  );

  // simple access-port slave
  logic [DATA_W-1:0] ap_mem [NAP];
  assign ap_rdata = ap_mem[ap_addr];
  always @(negedge clk) if (ap_wr_en) ap_mem[ap_addr] <= ap_wdata;

  // reference model state
  int errors = 0, checks = 0;
  bit done = 0;
  bit m_locked = 0, m_sticky = 0;
  logic [7:0] m_ctrl = '0;
  logic [BANK_W-1:0] m_bank = '0;
  logic [31:0] m_rdbuf = '0;
  logic [31:0] m_ap [NAP];
  bit pend_wr = 0;
  logic [BANK_W+1:0] pend_addr;
  logic [31:0] pend_data;

  function automatic logic [31:0] dp_model(input logic [1:0] a);
    case (a)
      2'd0: return IDC;
      2'd1: return {16'h0, m_ctrl, 7'h0, m_sticky};
      2'd2: return {28'h0, m_bank};
      default: return m_rdbuf;
    endcase
  endfunction

  task automatic step(input bit hb, input bit eoe, input bit ev, input bit erd, input string rq);
    bit ewr = pend_wr;
    @(negedge clk);
    checks++;
    if (swdio_oe !== eoe || (eoe && swdio_out !== ev) || ap_rd_en !== erd ||
        ap_wr_en !== ewr || (ewr && (ap_addr !== pend_addr || ap_wdata !== pend_data))) begin
      errors++;
      $display("FAIL %s @%0t: oe=%b out=%b rd=%b wr=%b addr=%h wd=%h exp oe=%b out=%b rd=%b wr=%b addr=%h wd=%h",
               rq, $time, swdio_oe, swdio_out, ap_rd_en, ap_wr_en, ap_addr, ap_wdata,
               eoe, ev, erd, ewr, pend_addr, pend_data);
    end
    pend_wr  = 0;
    swdio_in = hb;
  endtask

  task automatic idle(input int n, input string rq);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, rq);
  endtask

  task automatic line_reset(input int n, input string rq);
    step(0, 0, 0, 0, rq);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, rq);
    step(0, 0, 0, 0, rq);
    if (n >= LR) m_locked = 0;
  endtask

  // hk: 0 good header, 1 parity flipped, 2 stop high, 3 park low
  task automatic txn(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd,
                     input int hk, input bit wbad, input string rq);
    bit [7:0] hb;
    logic [2:0] ack;
    logic [31:0] d;
    hb[0] = 1; hb[1] = ap; hb[2] = rnw; hb[3] = a[0]; hb[4] = a[1];
    hb[5] = (ap ^ rnw ^ a[0] ^ a[1]) ^ (hk == 1);
    hb[6] = (hk == 2); hb[7] = (hk != 3);
    for (int i = 0; i < 8; i++) step(hb[i], 0, 0, 0, rq);
    if (m_locked || hk != 0) begin
      m_locked = 1;
      return;
    end
    ack = (ap && m_sticky) ? 3'b100 : (ap && ap_busy) ? 3'b010 : 3'b001;
    step(0, 0, 0, ap && rnw && ack == 3'b001, rq);
    for (int i = 0; i < 3; i++) step(0, 1, ack[i], 0, rq);
    if (ack != 3'b001) begin
      step(0, 0, 0, 0, rq);
      return;
    end
    if (rnw) begin
      d = ap ? m_ap[{m_bank, a}] : dp_model(a);
      if (ap) m_rdbuf = d;
      for (int i = 0; i < 32; i++) step(0, 1, d[i], 0, rq);
      step(0, 1, ^d, 0, rq);
      step(0, 0, 0, 0, rq);
    end else begin
      step(0, 0, 0, 0, rq);
      for (int i = 0; i < 32; i++) step(wd[i], 0, 0, 0, rq);
      step((^wd) ^ wbad, 0, 0, 0, rq);
      if (wbad) m_sticky = 1;
      else if (ap) begin
        pend_wr = 1; pend_addr = {m_bank, a}; pend_data = wd;
        m_ap[{m_bank, a}] = wd;
      end else begin
        case (a)
          2'd0: if (wd[0]) m_sticky = 0;
          2'd1: m_ctrl = wd[15:8];
          2'd2: m_bank = wd[3:0];
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NAP; i++) begin
      ap_mem[i] = 32'h5A00_0000 + 32'(i * 32'h0101_0301);
      m_ap[i]   = ap_mem[i];
    end
    repeat (3) @(negedge clk);
    checks++;
    if (swdio_oe !== 1'b0 || ap_wr_en !== 1'b0 || ap_rd_en !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: oe=%b wr=%b rd=%b expected 0 0 0", swdio_oe, ap_wr_en, ap_rd_en);
    end
    rst = 0;
    line_reset(55, "R3 init");
    idle(2, "R12 idle");
    txn(0, 1, 2'd0, '0, 0, 0, "R4 idcode read");
    txn(0, 0, 2'd1, 32'h0000_A500, 0, 0, "R5 ctrl write");
    txn(0, 1, 2'd1, '0, 0, 0, "R10 ctrl read");
    txn(0, 0, 2'd2, 32'h0000_0003, 0, 0, "R10 bank write");
    txn(0, 1, 2'd2, '0, 0, 0, "R10 bank read");
    txn(1, 0, 2'd1, 32'hDEAD_BEEF, 0, 0, "R9 ap write");
    txn(1, 1, 2'd1, '0, 0, 0, "R9 ap read");
    txn(0, 0, 2'd3, 32'hFFFF_FFFF, 0, 0, "R10 rdbuf write ignored");
    txn(0, 1, 2'd3, '0, 0, 0, "R10 rdbuf read");
    txn(1, 0, 2'd1, 32'h1234_5678, 0, 1, "R6 ap bad parity");
    txn(0, 1, 2'd1, '0, 0, 0, "R6 sticky visible");
    txn(1, 1, 2'd2, '0, 0, 0, "R7 ap fault");
    txn(0, 1, 2'd0, '0, 0, 0, "R7 dp ok while sticky");
    ap_busy = 1;
    txn(1, 1, 2'd1, '0, 0, 0, "R8 fault over wait");
    txn(0, 0, 2'd0, 32'h0000_0001, 0, 0, "R7 clear sticky");
    txn(1, 0, 2'd0, 32'h0BAD_0BAD, 0, 0, "R8 ap write wait");
    txn(1, 1, 2'd1, '0, 0, 0, "R11 wait no data");
    ap_busy = 0;
    txn(1, 1, 2'd1, '0, 0, 0, "R6 ap data unchanged");
    txn(0, 0, 2'd1, 32'h0000_3C00, 0, 1, "R6 dp bad parity");
    txn(0, 1, 2'd1, '0, 0, 0, "R6 ctrl unchanged");
    txn(0, 0, 2'd0, 32'h0000_0001, 0, 0, "R7 clear again");
    txn(0, 1, 2'd1, '0, 0, 0, "R7 sticky cleared");
    idle(2, "R1 idle");
    txn(0, 1, 2'd0, '0, 1, 0, "R2 parity error");
    txn(0, 1, 2'd0, '0, 0, 0, "R2 silent after error");
    line_reset(49, "R3 short reset");
    txn(0, 1, 2'd0, '0, 0, 0, "R3 still locked");
    line_reset(50, "R3 full reset");
    txn(0, 1, 2'd0, '0, 0, 0, "R3 answers after reset");
    txn(0, 1, 2'd0, '0, 2, 0, "R2 stop error");
    line_reset(50, "R3 reset");
    txn(0, 1, 2'd0, '0, 3, 0, "R2 park error");
    line_reset(60, "R3 reset");
    txn(1, 1, 2'd0, '0, 0, 0, "R9 ap read bank3");
    idle(3, "R1 tail");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule